// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block guards entry into the flash program and erase modes. Software writes a small control register and two erase-block select registers through a simple bus port. The block combines those bits with several system conditions and reports the mode the flash array may be in: idle, program or erase. It also raises a protected status whenever programming and erasing are locked out.

Protection works at two levels. The hardware level covers the flash write-enable input pin being low, a system reset, a watchdog-overflow reset and standby. While any of these holds, every register returns to zero and any running operation is cut off at once. The software level covers the software-enable bit being clear or RAM emulation being selected. It does not touch the registers. It only refuses the move into program or erase mode.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the control register and both block registers become 0. While `rst_n` is low, `mode_o` is idle (2'b00) and `protected_o` is 1.
- R2: A high `wdt_rst` at a rising edge clears the control register and both block registers.
- R3: A high `standby` at a rising edge clears the control register and both block registers.
- R4: A low `wr_en_pin` at a rising edge clears all registers. A bus write made while `wr_en_pin` is low is ignored: after the pin returns high, the registers still read 0.
- R5: In the same cycle that `wdt_rst`, `standby` or a low `wr_en_pin` appears, `mode_o` shows idle. A program or erase already in progress is therefore aborted, and it stays idle after the condition ends.
- R6: The control register is at address 0. Its bit 0 is the program bit, bit 1 is the erase bit and bit 2 is the software-enable bit. With program=1, erase=0, software-enable=1, `ram_emu`=0 and no hardware condition, `mode_o` is program (2'b01).
- R7: With erase=1, program=0, software-enable=1, `ram_emu`=0, no hardware condition and at least one bit set in either block register, `mode_o` is erase (2'b10).
- R8: When software-enable is 0 or `ram_emu` is 1, `mode_o` stays idle whatever the program and erase bits hold, and the register contents are kept.
- R9: An erase request with both block registers equal to zero leaves `mode_o` idle.
- R10: Program and erase set together are invalid, and `mode_o` stays idle.
- R11: `protected_o` is 1 exactly when a hardware or a software protection condition is active.
- R12: `bus_rdata` returns the addressed register without delay: address 0 gives the control bits zero-extended, address 1 gives block register 0, address 2 gives block register 1, and address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wdt_rst | input | 1 | Watchdog-overflow reset, active high |
| standby | input | 1 | Standby mode indication, active high |
| wr_en_pin | input | 1 | Flash write-enable pin; low forces hardware protection |
| ram_emu | input | 1 | RAM emulation selected; high forces software protection |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| mode_o | output | 2 | Current mode: 00 idle, 01 program, 10 erase |
| protected_o | output | 1 | Program/erase protected status |

## Verification
There is one register stage, so timing splits into two kinds of result. A register write or a hardware clear shows up on `bus_rdata` and in `mode_o` one rising edge after it is driven. A change on `wdt_rst`, `standby`, `wr_en_pin` or `ram_emu` reaches `mode_o` and `protected_o` in the same cycle, before any edge. The bench drives inputs on the falling edge. For register effects it samples at the next falling edge. For the same-cycle abort it samples one nanosecond after the drive, so it sees the output before the clearing edge arrives.

// File: rtl/fg_pkg.sv
// Shared constants and types for the flash protection controller.
// Assumes an 8-bit register bus with a control register at address 0
// followed by the erase-block select registers.
package fg_pkg;
    localparam int DW        = 8;              // bus data width
    localparam int NBR       = 2;              // number of block registers
    localparam int NREG      = NBR + 2;        // control + blocks + one spare read slot
    localparam int AW        = $clog2(NREG);   // address width
    localparam int CTRL_W    = 3;              // implemented control bits
    localparam int BIT_PRG   = 0;
    localparam int BIT_ERS   = 1;
    localparam int BIT_SWEN  = 2;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_PROG  = 2'b01,
        MODE_ERASE = 2'b10
    } fg_mode_e;
endpackage

// File: rtl/fg_regs.sv
// Register file: control register plus NBR erase-block registers.
// Assumes a synchronous active-low reset; hw_clr forces every register
// to zero and takes priority over a bus write in the same cycle.
module fg_regs
    import fg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_clr,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [NBR*DW-1:0] blk_flat,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] blk_q [NBR];

    // Control register: cleared by reset or hardware protection, else written.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_clr)
            ctrl_q <= '0;
        else if (we && addr == AW'(0))
            ctrl_q <= wdata[CTRL_W-1:0];
    end

    for (genvar g = 0; g < NBR; g++) begin : g_blk
        // Block register g: same clear rule, written at address g+1.
        always_ff @(posedge clk) begin
            if (!rst_n || hw_clr)
                blk_q[g] <= '0;
            else if (we && addr == AW'(g + 1))
                blk_q[g] <= wdata;
        end
        assign blk_flat[g*DW +: DW] = blk_q[g];
    end

    // Read mux: addressed register, zero for unmapped slots.
    always_comb begin
        rdata = '0;
        if (addr == AW'(0))
            rdata[CTRL_W-1:0] = ctrl_q;
        for (int i = 0; i < NBR; i++) begin
            if (addr == AW'(i + 1))
                rdata = blk_q[i];
        end
    end
endmodule

// File: rtl/fg_protect.sv
// Protection evaluator: reduces system conditions and the software-enable
// bit to a hardware-active flag, a software-active flag and the status.
// Purely combinational; assumes all inputs are synchronous to clk.
module fg_protect (
    input  logic rst_n,
    input  logic wdt_rst,
    input  logic standby,
    input  logic wr_en_pin,
    input  logic ram_emu,
    input  logic swen,
    output logic hw_clr,
    output logic hw_act,
    output logic sw_act,
    output logic prot
);
    // Conditions that clear registers (reset handled inside the registers).
    assign hw_clr = wdt_rst || standby || !wr_en_pin;
    // Any hardware lockout, reset included.
    assign hw_act = hw_clr || !rst_n;
    // Software lockout leaves registers intact.
    assign sw_act = !swen || ram_emu;
    assign prot   = hw_act || sw_act;
endmodule

// File: rtl/fg_mode.sv
// Mode decision: grants program or erase only when no lockout is active,
// the request is unambiguous and, for erase, a block is selected.
// Combinational so that a hardware condition idles the mode at once.
module fg_mode
    import fg_pkg::*;
(
    input  logic     hw_act,
    input  logic     sw_act,
    input  logic     prg,
    input  logic     ers,
    input  logic     blk_any,
    output fg_mode_e mode
);
    // Priority: lockouts, then invalid request, then program, then erase.
    always_comb begin
        mode = MODE_IDLE;
        if (!hw_act && !sw_act && !(prg && ers)) begin
            if (prg)
                mode = MODE_PROG;
            else if (ers && blk_any)
                mode = MODE_ERASE;
        end
    end
endmodule

// File: rtl/flash_guard.sv
// Top of the flash program/erase protection controller.
// Assumes synchronous inputs and a synchronous active-low reset.
module flash_guard
    import fg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wdt_rst,
    input  logic          standby,
    input  logic          wr_en_pin,
    input  logic          ram_emu,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [1:0]    mode_o,
    output logic          protected_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [NBR*DW-1:0] blk_flat;
    logic              hw_clr, hw_act, sw_act;
    fg_mode_e          mode;

    fg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_clr   (hw_clr),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .blk_flat (blk_flat),
        .rdata    (bus_rdata)
    );

    fg_protect u_prot (
        .rst_n     (rst_n),
        .wdt_rst   (wdt_rst),
        .standby   (standby),
        .wr_en_pin (wr_en_pin),
        .ram_emu   (ram_emu),
        .swen      (ctrl_q[BIT_SWEN]),
        .hw_clr    (hw_clr),
        .hw_act    (hw_act),
        .sw_act    (sw_act),
        .prot      (protected_o)
    );

    fg_mode u_mode (
        .hw_act  (hw_act),
        .sw_act  (sw_act),
        .prg     (ctrl_q[BIT_PRG]),
        .ers     (ctrl_q[BIT_ERS]),
        .blk_any (|blk_flat),
        .mode    (mode)
    );

    assign mode_o = mode;
endmodule

// File: rtl/flash_guard_chk.sv
// Checker for flash_guard: relates conditions, register state and the
// mode/status outputs over time. Bound to every flash_guard instance.
module flash_guard_chk
    import fg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_rst,
    input logic              standby,
    input logic              wr_en_pin,
    input logic              ram_emu,
    input logic              bus_we,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [NBR*DW-1:0] blk_flat,
    input logic [1:0]        mode_o,
    input logic              protected_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && blk_flat == '0));

    a_r2_wdt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> (ctrl_q == '0 && blk_flat == '0));

    a_r3_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ctrl_q == '0 && blk_flat == '0));

    a_r4_pin_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_pin |=> (ctrl_q == '0 && blk_flat == '0));

    a_r5_hw_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst || standby || !wr_en_pin) |-> mode_o == MODE_IDLE);

    a_r8_sw_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[BIT_SWEN] || ram_emu) |-> mode_o == MODE_IDLE);

    a_r8_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_emu && !bus_we && wr_en_pin && !wdt_rst && !standby)
        |=> ($stable(ctrl_q) && $stable(blk_flat)));

    a_r9_no_block_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_flat == '0) |-> mode_o != MODE_ERASE);

    a_r10_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_PRG] && ctrl_q[BIT_ERS]) |-> mode_o == MODE_IDLE);

    a_r11_active_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_IDLE) |-> !protected_o);
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_rst     (wdt_rst),
    .standby     (standby),
    .wr_en_pin   (wr_en_pin),
    .ram_emu     (ram_emu),
    .bus_we      (bus_we),
    .ctrl_q      (ctrl_q),
    .blk_flat    (blk_flat),
    .mode_o      (mode_o),
    .protected_o (protected_o)
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_rst = 1'b0, standby = 1'b0, wr_en_pin = 1'b1, ram_emu = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] mode_o;
    logic       protected_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    flash_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .standby(standby),
        .wr_en_pin(wr_en_pin), .ram_emu(ram_emu), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_o(mode_o), .protected_o(protected_o)
    );

    // Vector: {ram_emu, ctrl, blk0, blk1, exp_mode, exp_prot, req}
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 8'h05, 8'h00, 8'h00, 2'd1, 1'b0, 4'd6},   // R6 program
        {1'b0, 8'h06, 8'h01, 8'h00, 2'd2, 1'b0, 4'd7},   // R7 erase, low block
        {1'b0, 8'h06, 8'h00, 8'h80, 2'd2, 1'b0, 4'd7},   // R7 erase, high block
        {1'b0, 8'h06, 8'h00, 8'h00, 2'd0, 1'b0, 4'd9},   // R9 no block
        {1'b0, 8'h07, 8'h01, 8'h00, 2'd0, 1'b0, 4'd10},  // R10 both bits
        {1'b0, 8'h01, 8'h00, 8'h00, 2'd0, 1'b1, 4'd8},   // R8 no software enable
        {1'b1, 8'h05, 8'h00, 8'h00, 2'd0, 1'b1, 4'd8},   // R8 RAM emulation
        {1'b0, 8'h04, 8'h00, 8'h00, 2'd0, 1'b0, 4'd11},  // R11 enabled, no request
        {1'b0, 8'h02, 8'h01, 8'h00, 2'd0, 1'b1, 4'd8},   // R8 erase, not enabled
        {1'b1, 8'h07, 8'h00, 8'h00, 2'd0, 1'b1, 4'd11}   // R11 RAM emulation status
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic regs_zero(input string req);
        logic [7:0] d;
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], d);
            chk(d == 8'h00, req, d, 0);
        end
    endtask

    task automatic start_prog;
        wr(2'd0, 8'h05);
        #1 chk(mode_o == 2'd1, "R6 setup", mode_o, 1);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(mode_o == 2'd0, "R1 mode in reset", mode_o, 0);
        chk(protected_o == 1'b1, "R1 protected in reset", protected_o, 1);
        regs_zero("R1 regs in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            ram_emu = 1'b0;
            wr(2'd1, v[22:15]);
            wr(2'd2, v[14:7]);
            wr(2'd0, v[30:23]);
            ram_emu = v[31];
            #1;
            chk(mode_o == v[6:5], $sformatf("R%0d vec%0d mode", v[3:0], i), mode_o, v[6:5]);
            chk(protected_o == v[4], $sformatf("R%0d vec%0d prot", v[3:0], i), protected_o, v[4]);
        end

        // R8: RAM emulation keeps register contents
        rd(2'd0, d);
        chk(d == 8'h07, "R8 ctrl kept", d, 8'h07);
        ram_emu = 1'b0;

        // R12: read map and masking of unimplemented control bits
        wr(2'd0, 8'hF8);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'h3C);
        rd(2'd0, d); chk(d == 8'h00, "R12 ctrl masked", d, 0);
        rd(2'd1, d); chk(d == 8'hA5, "R12 blk0", d, 8'hA5);
        rd(2'd2, d); chk(d == 8'h3C, "R12 blk1", d, 8'h3C);
        rd(2'd3, d); chk(d == 8'h00, "R12 spare", d, 0);

        // R2/R5: watchdog reset aborts program mode in the same cycle
        start_prog();
        wdt_rst = 1'b1;
        #1;
        chk(mode_o == 2'd0, "R5 wdt same-cycle idle", mode_o, 0);
        chk(protected_o == 1'b1, "R11 wdt protected", protected_o, 1);
        @(negedge clk);
        wdt_rst = 1'b0;
        regs_zero("R2 regs after wdt");
        chk(mode_o == 2'd0, "R5 stays idle after wdt", mode_o, 0);

        // R3/R5: standby aborts erase
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h06);
        #1 chk(mode_o == 2'd2, "R7 setup erase", mode_o, 2);
        @(negedge clk);
        standby = 1'b1;
        #1 chk(mode_o == 2'd0, "R5 standby same-cycle idle", mode_o, 0);
        @(negedge clk);
        standby = 1'b0;
        regs_zero("R3 regs after standby");

        // R4/R5: pin low clears and blocks writes
        start_prog();
        @(negedge clk);
        wr_en_pin = 1'b0;
        #1 chk(mode_o == 2'd0, "R5 pin same-cycle idle", mode_o, 0);
        chk(protected_o == 1'b1, "R11 pin protected", protected_o, 1);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'hFF);
        wr_en_pin = 1'b1;
        @(negedge clk);
        regs_zero("R4 writes ignored");
        chk(mode_o == 2'd0, "R4 mode idle", mode_o, 0);

        // R1: system reset during program
        start_prog();
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk(mode_o == 2'd0, "R1 reset idle", mode_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        regs_zero("R1 regs after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule